// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter

This block is a small binary up-counter, four bits wide by default, whose every change of state happens on the rising clock edge. Four controls pick what happens at each edge. An active-low clear forces the count to zero. An active-low load copies the parallel data inputs into the register. Two active-high enables must both be high for the count to advance by one. In every other case the count holds its value.

The block is built to be chained into wider counters. Its chain output is high only when the count is all ones and the chain enable is high. It is a combinational function of the register and that one enable, and the run enable has no part in it. A higher stage therefore takes the lower stage's chain output on its own chain enable and sees it in the same cycle. All stages share one run enable, so the carry does not ripple through a column of enable gates.

Top module: `sync_bin_counter`

## Requirements
- R1: When `clear_n` is low at a rising edge, `count` becomes zero at that edge, whatever the values of `load_n`, `run_en`, `chain_en` and `d_in`.
- R2: When `clear_n` is high and `load_n` is low at a rising edge, `count` takes the value of `d_in` at that edge, whatever the two enables are.
- R3: When `clear_n` and `load_n` are high and both `run_en` and `chain_en` are high at a rising edge, `count` increases by exactly one.
- R4: When `clear_n` and `load_n` are high and either `run_en` or `chain_en` is low at a rising edge, `count` keeps its value.
- R5: `chain_out` is high exactly when `count` is all ones (15 at the default width) and `chain_enable` is high. It responds to `chain_en` in the same cycle, with no register, and `run_en` has no effect on it.
- R6: A counting edge at the all-ones value wraps `count` to zero.
- R7: Two stages chained output-to-enable, with a shared run enable, count together as one 8-bit counter from 0 to 255 and wrap to 0. The upper stage advances only on the edge where the lower stage leaves 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| run_en | input | 1 | Count enable that is shared by all stages |
| chain_en | input | 1 | Count enable that also gates the chain output |
| d_in | input | WIDTH | Parallel load data |
| count | output | WIDTH | Registered count value |
| chain_out | output | 1 | All-ones indication, gated by chain_en |

## Verification
The register holds no defined value after power-up. The checker therefore stays silent until it has seen a clear or a load at some edge. From that edge on it takes the controls to be driven with defined levels, changing only away from the rising edge. The bench keeps to this: it changes every input on the falling edge and issues a clear before any count check. The cascade is cleared as a pair before it is walked through its 256 states.

// File: rtl/sync_bin_counter_pkg.sv
package sync_bin_counter_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_e;
endpackage

// File: rtl/sbc_mode_sel.sv
module sbc_mode_sel
  import sync_bin_counter_pkg::*;
(
  input  logic  clear_n,
  input  logic  load_n,
  input  logic  run_en,
  input  logic  chain_en,
  output mode_e mode
);
  // fixed priority: clear, load, count, hold
  always_comb begin
    if (!clear_n)                mode = MODE_CLEAR;
    else if (!load_n)            mode = MODE_LOAD;
    else if (run_en && chain_en) mode = MODE_COUNT;
    else                         mode = MODE_HOLD;
  end
endmodule

// File: rtl/sbc_incr.sv
module sbc_incr #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  // ripple of half adders; carry out of the top bit is dropped (wrap)
  logic [WIDTH:0] c;
  assign c[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_ha
    assign nxt[i]  = cur[i] ^ c[i];
    assign c[i+1]  = cur[i] & c[i];
  end
endmodule

// File: rtl/sbc_chain.sv
module sbc_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             chain_en,
  output logic             chain_out
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  assign chain_out = chain_en && (cur == ALL_ONES);
endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
  import sync_bin_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             run_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] count,
  output logic             chain_out
);
  mode_e            mode;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] cnt_q;

  sbc_mode_sel u_mode (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .run_en   (run_en),
    .chain_en (chain_en),
    .mode     (mode)
  );

  sbc_incr #(.WIDTH(WIDTH)) u_incr (
    .cur (cnt_q),
    .nxt (inc_val)
  );

  always_ff @(posedge clk) begin
    unique case (mode)
      MODE_CLEAR: cnt_q <= '0;
      MODE_LOAD:  cnt_q <= d_in;
      MODE_COUNT: cnt_q <= inc_val;
      default:    cnt_q <= cnt_q;
    endcase
  end

  sbc_chain #(.WIDTH(WIDTH)) u_chain (
    .cur       (cnt_q),
    .chain_en  (chain_en),
    .chain_out (chain_out)
  );

  assign count = cnt_q;
endmodule

// File: rtl/sync_bin_counter_chk.sv
module sync_bin_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic             run_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] d_in,
  input logic [WIDTH-1:0] count,
  input logic             chain_out
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // becomes high once the register has been given a defined value
  logic primed = 1'b0;
  always_ff @(posedge clk)
    if (!clear_n || !load_n) primed <= 1'b1;

  wire adv = clear_n && load_n && run_en && chain_en;

  p_clear_zero_r1: assert property (@(posedge clk)
    !clear_n |=> count == '0);

  p_load_capture_r2: assert property (@(posedge clk) disable iff (!primed)
    (clear_n && !load_n) |=> count == $past(d_in));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!primed)
    (adv && count != TOP) |=> count == $past(count) + 1'b1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!primed)
    (clear_n && load_n && !(run_en && chain_en)) |=> $stable(count));

  p_chain_needs_top_r5: assert property (@(posedge clk) disable iff (!primed)
    chain_out |-> (count == TOP && chain_en));

  p_chain_seen_r5: assert property (@(posedge clk) disable iff (!primed)
    (count == TOP && chain_en) |-> chain_out);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!primed)
    (adv && count == TOP) |=> count == '0);
endmodule

bind sync_bin_counter sync_bin_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .run_en    (run_en),
  .chain_en  (chain_en),
  .d_in      (d_in),
  .count     (count),
  .chain_out (chain_out)
);

// File: tb/tb_sync_bin_counter.sv
module tb_sync_bin_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // single stage under table test
  logic       clear_n = 1'b1, load_n = 1'b1, run_en = 1'b0, chain_en = 1'b0;
  logic [3:0] d_in = '0;
  logic [3:0] count;
  logic       chain_out;

  sync_bin_counter #(.WIDTH(4)) dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .run_en(run_en),
    .chain_en(chain_en), .d_in(d_in), .count(count), .chain_out(chain_out)
  );

  // two-stage cascade
  logic       c_clear_n = 1'b1, c_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;

  sync_bin_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .run_en(c_en),
    .chain_en(c_en), .d_in(4'h0), .count(lo_q), .chain_out(lo_co)
  );
  sync_bin_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clear_n(c_clear_n), .load_n(1'b1), .run_en(c_en),
    .chain_en(lo_co), .d_in(4'h0), .count(hi_q), .chain_out(hi_co)
  );

  // {req, clear_n, load_n, run_en, chain_en, d_in, exp_count, exp_chain}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd1, 4'b0111, 4'h5, 4'h0, 1'b0},  // clear
    {4'd2, 4'b1011, 4'h9, 4'h9, 1'b0},  // load 9
    {4'd3, 4'b1111, 4'h0, 4'hA, 1'b0},  // count
    {4'd4, 4'b1101, 4'h0, 4'hA, 1'b0},  // run low
    {4'd4, 4'b1110, 4'h0, 4'hA, 1'b0},  // chain low
    {4'd4, 4'b1100, 4'h0, 4'hA, 1'b0},  // both low
    {4'd1, 4'b0011, 4'h7, 4'h0, 1'b0},  // clear beats load
    {4'd2, 4'b1011, 4'hE, 4'hE, 1'b0},  // load beats count
    {4'd3, 4'b1111, 4'h0, 4'hF, 1'b1},  // count to top
    {4'd5, 4'b1101, 4'h0, 4'hF, 1'b1},  // carry ignores run_en
    {4'd5, 4'b1110, 4'h0, 4'hF, 1'b0},  // carry gated by chain_en
    {4'd6, 4'b1111, 4'h0, 4'h0, 1'b0},  // wrap
    {4'd2, 4'b1000, 4'hF, 4'hF, 1'b0},  // load with enables low
    {4'd1, 4'b0100, 4'h3, 4'h0, 1'b0}   // clear with enables low
  };

  function automatic string rq(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    // table walk: drive on falling edge, sample 1 time unit after rising edge
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {clear_n, load_n, run_en, chain_en} = VEC[i][12:9];
      d_in = VEC[i][8:5];
      @(posedge clk);
      #1;
      check(rq(int'(VEC[i][16:13])), count, VEC[i][4:1]);
      check(rq(int'(VEC[i][16:13])), chain_out, VEC[i][0]);
    end

    // R5: carry follows chain_en in the same cycle, no edge in between
    @(negedge clk);
    clear_n = 1'b1; load_n = 1'b0; d_in = 4'hF; run_en = 1'b0; chain_en = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    #1 check("R5", chain_out, 0);
    chain_en = 1'b1;
    #1 check("R5", chain_out, 1);
    chain_en = 1'b0;
    #1 check("R5", chain_out, 0);

    // R7: cascade cleared, then walked through all 256 states
    @(negedge clk);
    c_clear_n = 1'b0;
    @(negedge clk);
    c_clear_n = 1'b1;
    check("R7", {hi_q, lo_q}, 0);
    c_en = 1'b1;
    for (int n = 1; n <= 256; n++) begin
      @(negedge clk);
      check("R7", {hi_q, lo_q}, n % 256);
      if (n == 255) check("R7", hi_co, 1);
      if (n == 254) check("R7", hi_co, 0);
    end
    // shared enable low freezes the pair
    c_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R7", {hi_q, lo_q}, 0);

    finish_run();
  end
endmodule